// File: doc/BRIEF.md
# Program-Fetch Bus Monitor

This block observes the external program-memory bus of a small 8-bit microcontroller and reports every instruction fetch as a compact record. The observed pins are: an 8-bit multiplexed address/data bus, a 4-bit upper-address port, an optional bank pin, the address-latch strobe and the active-low program-read strobe. The block samples all of them with a fast system clock. Each pin passes through the same synchronizer depth, so address, data and strobes stay aligned in time. The block finds the strobe edges from consecutive synchronized samples.

A falling address-latch strobe fixes the fetch address. The low byte comes from the multiplexed bus and bits 11:8 come from the upper port. When `bankEn` is set, the bank pin becomes bit 12, which doubles the space to 8 KiB. The rising (deasserting) edge of the read strobe captures the opcode byte. Each captured fetch becomes a 3-byte record: address high byte, then address low byte, then opcode byte. The record leaves on a byte stream with a valid/ready handshake.

A one-entry holding slot sits between the bus and the serializer. A record that arrives while the slot is still occupied replaces the older one and sets a sticky overflow flag.

Top module: `fetch_bus_monitor`

## Requirements
- R1: On a falling edge of `aleIn`, the block stores the fetch address. Bits 7:0 are taken from `busData` and bits 11:8 from `busAddrHi`, both as they were sampled together with that edge.
- R2: Address bit 12 equals `bankBit` sampled at the address-latch edge when `bankEn` is 1. It is 0 when `bankEn` is 0. The first record byte carries address bits 12:8 in its bits 4:0, and bits 7:5 of that byte are 0.
- R3: The third record byte is the value of `busData` sampled at the rising edge of `strobeN`.
- R4: A rising edge of `strobeN` produces no record until at least one falling edge of `aleIn` has been seen since reset.
- R5: A record is sent as three bytes in this order: address high, address low, opcode. `mTlast` is 1 only on the opcode byte. After the opcode byte is accepted, `mTvalid` is 0 for at least one cycle.
- R6: A falling edge of `aleIn` and a rising edge of `strobeN` may fall in the same sample. The block then processes the new address first and emits a record with it, even if this is the first address edge since reset.
- R7: While `mTvalid` is 1 and `mTready` is 0, `mTdata`, `mTlast` and `mTvalid` hold their values.
- R8: A new record may arrive while the holding slot is still full and is not moving to the serializer in that cycle. The new record then replaces the held one, and `overflow` goes to 1 and stays 1 until reset.
- R9: Reset clears the stored address, the held record, the serializer, the started state and `overflow`. After reset, `mTvalid` is 0, `overflow` is 0, and a lone read-strobe pulse emits nothing.
- R10: A rising edge of `strobeN` is present on the pins before some rising clock edge. The first byte of its record is then valid after the fourth rising clock edge, counting that edge as the first, provided the serializer and holding slot are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busData | input | 8 | Multiplexed low address / opcode bus |
| busAddrHi | input | 4 | Address bits 11:8 |
| bankBit | input | 1 | Optional bank pin, used as address bit 12 |
| aleIn | input | 1 | Address-latch strobe; its fall latches the address |
| strobeN | input | 1 | Active-low program-read strobe; its rise captures the opcode |
| bankEn | input | 1 | Static: 1 includes the bank pin in the address |
| mTdata | output | 8 | Record byte |
| mTvalid | output | 1 | Record byte valid |
| mTready | input | 1 | Downstream accepts the byte |
| mTlast | output | 1 | Marks the opcode byte, the last of a record |
| overflow | output | 1 | Sticky: a held record was overwritten |

## Verification
The main function is tried with five kinds of pattern:

- Separate address and read phases with `bankEn` off and on, driving the bank pin high. These show whether bit 12 follows the enable.
- Address values that set only high bits or only low bits. These show whether the upper nibble and the low byte land in the right record bytes.
- A read pulse with no preceding address edge. This tells a started monitor apart from a fresh one.
- A single sample holding both edges, which shows whether the address is processed before the opcode.
- A stalled consumer that forces three records into a slot built for two. This shows which record is dropped and whether the flag sticks.

Alongside these patterns, a cycle-level model tracks latency, byte order and `mTlast` on every clock under steady, throttled and blocked `mTready`.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic latchAddr;  // take a new address from the synchronized pins
    logic pendWrite;  // write a fresh record into the holding slot
    logic loadOut;    // move the holding slot into the serializer
  } ctrlStrobes_t;

endpackage

// File: rtl/fbm_datapath.sv
module fbm_datapath
  import fbm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HI_W       = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int ADDR_W     = DATA_W + HI_W + 1,
  parameter int REC_BYTES  = 3,
  parameter int IDX_W      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    busData,
  input  logic [HI_W-1:0]      busAddrHi,
  input  logic                 bankBit,
  input  logic                 aleIn,
  input  logic                 strobeN,
  input  logic                 bankEn,
  input  ctrlStrobes_t         ctl,
  input  logic [IDX_W-1:0]     byteIdx,
  output logic                 aleNow,
  output logic                 alePrev,
  output logic                 strNow,
  output logic                 strPrev,
  output logic [7:0]           mTdata
);

  localparam int PIN_W  = DATA_W + HI_W + 3;
  localparam int AW_PAD = 8 * (REC_BYTES - 1);
  localparam int REC_W  = 8 * REC_BYTES;
  localparam logic [PIN_W-1:0] PINS_IDLE = PIN_W'(1);  // strobe high, latch low

  // stage SYNC_DEPTH-1 is the current sample, stage SYNC_DEPTH the previous one
  logic [PIN_W-1:0] stageQ [0:SYNC_DEPTH];
  logic [PIN_W-1:0] pinsIn;
  logic [PIN_W-1:0] curPins;
  logic [PIN_W-1:0] prevPins;

  logic [DATA_W-1:0] curData;
  logic [HI_W-1:0]   curHi;
  logic              curBank;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] addrNext;
  logic [AW_PAD-1:0] addrPad;
  logic [REC_W-1:0]  pendQ;
  logic [REC_W-1:0]  outQ;

  assign pinsIn   = {bankBit, busAddrHi, busData, aleIn, strobeN};
  assign curPins  = stageQ[SYNC_DEPTH-1];
  assign prevPins = stageQ[SYNC_DEPTH];

  assign strNow   = curPins[0];
  assign strPrev  = prevPins[0];
  assign aleNow   = curPins[1];
  assign alePrev  = prevPins[1];
  assign curData  = curPins[DATA_W+1:2];
  assign curHi    = curPins[DATA_W+HI_W+1:DATA_W+2];
  assign curBank  = curPins[PIN_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC_DEPTH; i++) stageQ[i] <= PINS_IDLE;
    end else begin
      stageQ[0] <= pinsIn;
      for (int i = 1; i <= SYNC_DEPTH; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  // a same-sample address edge must reach the record built in this cycle
  assign addrNext = ctl.latchAddr ? {bankEn & curBank, curHi, curData} : addrQ;
  assign addrPad  = AW_PAD'(addrNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      pendQ <= '0;
      outQ  <= '0;
    end else begin
      if (ctl.latchAddr) addrQ <= addrNext;
      if (ctl.pendWrite) pendQ <= {addrPad, curData};
      if (ctl.loadOut)   outQ  <= pendQ;
    end
  end

  assign mTdata = outQ[REC_W - 1 - 8*byteIdx -: 8];

  AST_BANK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchAddr && !bankEn) |=> (addrQ[ADDR_W-1] == 1'b0)); // R2

endmodule

// File: rtl/fbm_control.sv
module fbm_control
  import fbm_pkg::*;
#(
  parameter int REC_BYTES = 3,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aleNow,
  input  logic             alePrev,
  input  logic             strNow,
  input  logic             strPrev,
  input  logic             mTready,
  output ctrlStrobes_t     ctl,
  output logic [IDX_W-1:0] byteIdx,
  output logic             mTvalid,
  output logic             mTlast,
  output logic             overflow
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  logic aleFall;
  logic strRise;
  logic startedQ;
  logic startedNext;
  logic pendValidQ;
  logic busyQ;
  logic ovfQ;
  logic [IDX_W-1:0] idxQ;

  assign aleFall     = alePrev & ~aleNow;
  assign strRise     = ~strPrev & strNow;
  assign startedNext = startedQ | aleFall;

  always_comb begin
    ctl.latchAddr = aleFall;
    ctl.pendWrite = strRise & startedNext;
    ctl.loadOut   = pendValidQ & ~busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startedQ   <= 1'b0;
      pendValidQ <= 1'b0;
      busyQ      <= 1'b0;
      idxQ       <= '0;
      ovfQ       <= 1'b0;
    end else begin
      startedQ <= startedNext;
      if (busyQ && mTready) begin
        if (idxQ == LAST_IDX) busyQ <= 1'b0;
        else                  idxQ  <= idxQ + 1'b1;
      end
      if (ctl.loadOut) begin
        busyQ <= 1'b1;
        idxQ  <= '0;
      end
      if (ctl.pendWrite) begin
        pendValidQ <= 1'b1;
        if (pendValidQ && !ctl.loadOut) ovfQ <= 1'b1;
      end else if (ctl.loadOut) begin
        pendValidQ <= 1'b0;
      end
    end
  end

  assign byteIdx  = idxQ;
  assign mTvalid  = busyQ;
  assign mTlast   = busyQ && (idxQ == LAST_IDX);
  assign overflow = ovfQ;

  AST_NO_REC_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    !startedQ |-> (!pendValidQ && !busyQ)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && mTready && mTlast) |=> !mTvalid); // R5

endmodule

// File: rtl/fetch_bus_monitor.sv
module fetch_bus_monitor
  import fbm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HI_W       = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic [HI_W-1:0]   busAddrHi,
  input  logic              bankBit,
  input  logic              aleIn,
  input  logic              strobeN,
  input  logic              bankEn,
  output logic [7:0]        mTdata,
  output logic              mTvalid,
  input  logic              mTready,
  output logic              mTlast,
  output logic              overflow
);

  localparam int ADDR_W    = DATA_W + HI_W + 1;
  localparam int REC_BYTES = (ADDR_W + 7) / 8 + 1;
  localparam int IDX_W     = $clog2(REC_BYTES);

  ctrlStrobes_t     ctl;
  logic [IDX_W-1:0] byteIdx;
  logic aleNow, alePrev, strNow, strPrev;

  fbm_datapath #(
    .DATA_W(DATA_W), .HI_W(HI_W), .SYNC_DEPTH(SYNC_DEPTH),
    .ADDR_W(ADDR_W), .REC_BYTES(REC_BYTES), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .busData(busData), .busAddrHi(busAddrHi), .bankBit(bankBit),
    .aleIn(aleIn), .strobeN(strobeN), .bankEn(bankEn),
    .ctl(ctl), .byteIdx(byteIdx),
    .aleNow(aleNow), .alePrev(alePrev), .strNow(strNow), .strPrev(strPrev),
    .mTdata(mTdata)
  );

  fbm_control #(.REC_BYTES(REC_BYTES), .IDX_W(IDX_W)) u_control (
    .clk(clk), .rstN(rstN),
    .aleNow(aleNow), .alePrev(alePrev), .strNow(strNow), .strPrev(strPrev),
    .mTready(mTready), .ctl(ctl), .byteIdx(byteIdx),
    .mTvalid(mTvalid), .mTlast(mTlast), .overflow(overflow)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTlast))); // R7

endmodule

// File: tb/fetch_bus_monitor_bench.sv
module fetch_bus_monitor_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       rstN = 1'b0;
  logic [7:0] busData = '0;
  logic [3:0] busAddrHi = '0;
  logic       bankBit = 1'b0;
  logic       aleIn = 1'b0;
  logic       strobeN = 1'b1;
  logic       bankEn = 1'b0;
  logic [7:0] mTdata;
  logic       mTvalid;
  logic       mTready = 1'b1;
  logic       mTlast;
  logic       overflow;

  fetch_bus_monitor u_fetch_bus_monitor (
    .clk(clk), .rstN(rstN), .busData(busData), .busAddrHi(busAddrHi),
    .bankBit(bankBit), .aleIn(aleIn), .strobeN(strobeN), .bankEn(bankEn),
    .mTdata(mTdata), .mTvalid(mTvalid), .mTready(mTready), .mTlast(mTlast),
    .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit compareOn = 0;
  bit benchStarted = 0;
  int readyMode = 0;
  int readyCyc = 0;
  int collected = 0;

  int    expByte[$];
  bit    expLast[$];
  string expTag[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- cycle-level reference model ----------------
  logic [14:0] m1 = 15'd1, m2 = 15'd1, mp = 15'd1;
  int  mAddr = 0;
  bit  mStarted = 0, mOvf = 0, pendV = 0;
  int  pendB[3];
  int  outQ[$];

  always @(posedge clk) begin
    bit aleFall, strRise, moveOut;
    int curD;
    if (!rstN) begin
      m1 = 15'd1; m2 = 15'd1; mp = 15'd1;
      mAddr = 0; mStarted = 0; mOvf = 0; pendV = 0; outQ.delete();
    end else begin
      aleFall = mp[1] && !m2[1];
      strRise = !mp[0] && m2[0];
      curD = int'(m2[9:2]);
      if (aleFall) begin
        mAddr = (bankEn ? int'(m2[14]) * 4096 : 0) + int'(m2[13:10]) * 256 + curD;
        mStarted = 1;
      end
      moveOut = pendV && (outQ.size() == 0);
      if (outQ.size() > 0 && mTready) void'(outQ.pop_front());
      if (moveOut) begin
        for (int k = 0; k < 3; k++) outQ.push_back(pendB[k]);
        pendV = 0;
      end
      if (strRise && mStarted) begin
        if (pendV) mOvf = 1;
        pendB[0] = mAddr / 256; pendB[1] = mAddr % 256; pendB[2] = curD;
        pendV = 1;
      end
      mp = m2; m2 = m1;
      m1 = {bankBit, busAddrHi, busData, aleIn, strobeN};
    end
  end

  // compare against the model on every clock (R10 timing, R8 flag)
  initial forever begin
    @(negedge clk);
    if (compareOn) begin
      chk(mTvalid == (outQ.size() > 0), "R10", "model valid", mTvalid, outQ.size() > 0);
      if (outQ.size() > 0) begin
        chk(mTdata == outQ[0], "R10", "model data", mTdata, outQ[0]);
        chk(mTlast == (outQ.size() == 1), "R5", "model last", mTlast, outQ.size() == 1);
      end
      chk(overflow == mOvf, "R8", "model overflow", overflow, mOvf);
    end
  end

  // ready pattern, changed away from both clock edges
  initial forever begin
    @(posedge clk); #1;
    case (readyMode)
      0: mTready = 1'b1;
      1: mTready = (readyCyc % 3) != 1;
      default: mTready = 1'b0;
    endcase
    readyCyc++;
  end

  // record collector against stimulus-derived expectations
  bit holdPend = 0;
  logic [7:0] holdData;
  bit holdLast;
  initial forever begin
    @(negedge clk);
    if (compareOn) begin
      if (holdPend) begin
        chk(mTvalid && mTdata == holdData && mTlast == holdLast, "R7", "held byte", mTdata, holdData);
      end
      holdPend = mTvalid && !mTready;
      holdData = mTdata;
      holdLast = mTlast;
      if (mTvalid && mTready) begin
        collected++;
        if (expByte.size() == 0) begin
          chk(0, "R4", "unexpected byte", mTdata, 0);
        end else begin
          chk(mTdata == expByte[0], expTag[0], "record byte", mTdata, expByte[0]);
          chk(mTlast == expLast[0], "R5", "last flag", mTlast, expLast[0]);
          void'(expByte.pop_front()); void'(expLast.pop_front()); void'(expTag.pop_front());
        end
      end
    end
  end

  task automatic pushRec(input int a, input int op, input string tagAddr);
    expByte.push_back(a / 256); expLast.push_back(0); expTag.push_back("R2");
    expByte.push_back(a % 256); expLast.push_back(0); expTag.push_back(tagAddr);
    expByte.push_back(op);      expLast.push_back(1); expTag.push_back("R3");
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    compareOn = 0;
    @(negedge clk);
    rstN = 1'b0;
    aleIn = 1'b0; strobeN = 1'b1;
    waitCyc(3);
    expByte.delete(); expLast.delete(); expTag.delete();
    benchStarted = 0; holdPend = 0; collected = 0;
    rstN = 1'b1;
    @(posedge clk); #1 compareOn = 1;
    @(negedge clk);
  endtask

  task automatic fetch(input logic [12:0] a, input logic [7:0] op, input bit expectIt);
    int ea;
    @(negedge clk);
    aleIn = 1'b1; busData = a[7:0]; busAddrHi = a[11:8]; bankBit = a[12];
    waitCyc(3);
    aleIn = 1'b0;
    benchStarted = 1;
    waitCyc(3);
    busData = op; strobeN = 1'b0;
    waitCyc(3);
    strobeN = 1'b1;
    ea = (bankEn ? int'(a[12]) * 4096 : 0) + int'(a[11:0]);
    if (expectIt && benchStarted) pushRec(ea, op, "R1");
    waitCyc(3);
  endtask

  task automatic strobeOnly(input logic [7:0] op);
    busData = op; strobeN = 1'b0;
    waitCyc(3);
    strobeN = 1'b1;
    waitCyc(3);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    chk(mTvalid == 0, "R9", "valid after reset", mTvalid, 0);
    chk(overflow == 0, "R9", "overflow after reset", overflow, 0);

    // R4: read pulse before any address edge
    strobeOnly(8'hE7);
    waitCyc(12);
    chk(collected == 0 && !mTvalid, "R4", "bytes before start", collected, 0);

    // R2 with bank disabled, bank pin driven high
    bankEn = 1'b0; readyMode = 0;
    fetch(13'h1ABC, 8'h5A, 1);
    fetch(13'h0123, 8'hC3, 1);
    fetch(13'h1FFF, 8'h00, 1);
    // R2 with bank enabled
    bankEn = 1'b1;
    fetch(13'h1F0E, 8'hA5, 1);
    fetch(13'h0801, 8'hFF, 1);
    fetch(13'h1000, 8'h3C, 1);
    waitCyc(10);

    // R7 throttled consumer
    readyMode = 1;
    for (int i = 0; i < 6; i++) fetch(13'(i * 613 + 7), 8'(i * 37 + 1), 1);
    waitCyc(20);

    // R8 blocked consumer: first sits in serializer, second overwritten by third
    readyMode = 2;
    fetch(13'h0AAA, 8'h11, 1);
    fetch(13'h0BBB, 8'h22, 0);
    chk(overflow == 0, "R8", "no overflow yet", overflow, 0);
    fetch(13'h1CCC, 8'h33, 1);
    waitCyc(4);
    chk(overflow == 1, "R8", "overflow set", overflow, 1);
    readyMode = 0;
    waitCyc(20);
    chk(overflow == 1, "R8", "overflow sticky", overflow, 1);
    chk(expByte.size() == 0, "R8", "pending bytes", expByte.size(), 0);

    // R9: reset clears flag and started state
    doReset();
    chk(overflow == 0, "R9", "overflow cleared", overflow, 0);
    strobeOnly(8'h77);
    waitCyc(12);
    chk(collected == 0 && !mTvalid, "R9", "no record after reset", collected, 0);

    // R6: both edges in one sample, first address edge since reset
    doReset();
    bankEn = 1'b1;
    aleIn = 1'b1; strobeN = 1'b0; busData = 8'h9D; busAddrHi = 4'h6; bankBit = 1'b1;
    waitCyc(3);
    aleIn = 1'b0; strobeN = 1'b1;
    benchStarted = 1;
    pushRec(13'h169D, 8'h9D, "R6");
    waitCyc(12);
    chk(collected == 3, "R6", "same-sample record bytes", collected, 3);
    fetch(13'h0456, 8'h42, 1);
    waitCyc(20);
    chk(expByte.size() == 0, "R1", "all records seen", expByte.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule